// File: doc/BRIEF.md
# Bit-banged serial word store

This block is a small non-volatile-style store of 128 sixteen-bit words that a processor reaches through one byte-wide pin register. Software toggles chip select, clock and data-in bits by writing that register and reads the serial data-out bit back from it. On each rising edge of the software clock the block takes in a start bit, a two-bit opcode and an eight-bit address field. It then carries out one of seven commands: read a word, write a word, erase a word, write all words, erase all words, allow modification, or forbid modification.

The pin register is hidden behind a two-key unlock. One key is written into bus region 0 and the other into bus region 2. Until both keys are in place, reads of the window return 0xFF and writes to it are dropped. When the opcode is 00, the two top bits of the address field choose the command. The data-out bit moves only on clock edges: it shows the data bit on a rising edge during a read, keeps its value across a falling edge while chip select is high, and reads as 1 (released line) on any other write.

Top module: `serial_word_store`

## Requirements
- R1: The window opens only while both keys are set. Writing 0x0A to region 0 sets key A, and any other value written there clears both keys. Writing 0x40 to region 2 sets key B, and any other value written there clears key B.
- R2: While the window is closed, `bus_rdata` is 0xFF and writes to the window region (5) leave the pin register unchanged.
- R3: While the window is open, `bus_rdata` returns the last byte written to the window in bits 7:1 and the current data-out in bit 0. The bit assignments are chip select = bit 7, clock = bit 6, data-in = bit 1, data-out = bit 0.
- R4: A window write that raises chip select sends the command sequencer back to idle, which aborts any command in progress.
- R5: In idle, a rising clock with data-in = 1 is a start bit. The next 10 rising edges shift in, MSB first, an opcode (10 read, 01 write, 11 erase, 00 extended) and an 8-bit field whose low 7 bits are the word address. For opcode 00, field bits 7:6 select 11 allow, 00 forbid, 01 write-all, 10 erase-all.
- R6: Allow sets the modify flag and forbid clears it. Write, erase, write-all and erase-all change nothing while the flag is clear.
- R7: Write takes 16 more data bits, MSB first, and stores them at the addressed word on the 16th edge.
- R8: Write-all takes 16 data bits and stores them in every word.
- R9: Erase sets the addressed word to 0xFFFF and erase-all sets every word to 0xFFFF, both on the last command edge.
- R10: Read drives data-out to 0 on the edge that takes the last address bit. It then presents the word MSB first on the next 16 rising edges and returns to idle.
- R11: A window write that lowers the clock while chip select is high keeps data-out at its previous value. Any other window write that is not a read data edge sets data-out to 1.
- R12: After reset, both keys and the modify flag are clear, every word holds `INIT_WORD`, and the pin register is 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_region | input | 3 | Region of the bus write (0 key A, 2 key B, 5 pin window) |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Pin register readback, or 0xFF when closed |

## Verification
The bench goes after the off-by-one points of the serial protocol. A design that miscounts the ten command bits, or that shifts the start bit in, would decode the wrong opcode or address and corrupt some other word. The dummy zero and the first data bit share a careful edge ordering: putting the dummy one edge late, or skipping it, makes every read come back shifted by one bit. The bench also checks the folding of the extended opcodes into the address field, modification attempts while forbidden, a chip-select restart partway through a command, a held data-out across falling edges during a read, and the asymmetric key clearing, where a wrong key A value clears both keys but a wrong key B value clears only its own.

// File: rtl/sws_pkg.sv
// Package: shared types and constants for the serial word store.
// Assumes: opcode and extended-code values are fixed by the serial protocol.
package sws_pkg;

    // Sequencer states that persist between edges
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMD   = 3'd1,
        ST_DOUT  = 3'd2,
        ST_WDATA = 3'd3,
        ST_WALL  = 3'd4
    } sws_state_e;

    // Two-bit opcodes
    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    // Extended codes carried in the top two address-field bits
    localparam logic [1:0] EXT_FORBID = 2'b00;
    localparam logic [1:0] EXT_WALL   = 2'b01;
    localparam logic [1:0] EXT_EALL   = 2'b10;
    localparam logic [1:0] EXT_ALLOW  = 2'b11;

    // Pin register bit positions
    localparam int PIN_CS  = 7;
    localparam int PIN_CLK = 6;
    localparam int PIN_DI  = 1;
    localparam int PIN_DO  = 0;

endpackage

// File: rtl/sws_unlock.sv
// Module: two-key gate for the pin window.
// Does: tracks key A and key B from bus writes and reports when both are set.
// Assumes: the key regions differ from each other.
module sws_unlock #(
    parameter int          REGION_W = 3,
    parameter int          A_REGION = 0,
    parameter int          B_REGION = 2,
    parameter logic [7:0]  A_VALUE  = 8'h0A,
    parameter logic [7:0]  B_VALUE  = 8'h40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [REGION_W-1:0] bus_region,
    input  logic [7:0]          bus_wdata,
    output logic                open_o
);

    logic key_a_q;
    logic key_b_q;
    logic hit_a;
    logic hit_b;

    // Decode which key region this write lands in
    always_comb begin
        hit_a = bus_wr && (bus_region == REGION_W'(A_REGION));
        hit_b = bus_wr && (bus_region == REGION_W'(B_REGION));
    end

    // Key registers: a wrong A value clears both, a wrong B value clears B
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_a_q <= 1'b0;
            key_b_q <= 1'b0;
        end else if (hit_a) begin
            if (bus_wdata == A_VALUE) begin
                key_a_q <= 1'b1;
            end else begin
                key_a_q <= 1'b0;
                key_b_q <= 1'b0;
            end
        end else if (hit_b) begin
            key_b_q <= (bus_wdata == B_VALUE);
        end
    end

    assign open_o = key_a_q && key_b_q;

    // A wrong value in region A closes the window on the next cycle
    assert_key_a_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && bus_wdata != A_VALUE) |=> !open_o);

    // A wrong value in region B closes the window on the next cycle
    assert_key_b_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_b && bus_wdata != B_VALUE) |=> !open_o);

endmodule

// File: rtl/sws_array.sv
// Module: word storage with one combinational read port and one write port.
// Does: writes a single word, or every word at once when wr_all is set.
// Assumes: wr_one and wr_all are never requested together.
module sws_array #(
    parameter int              WORDS     = 128,
    parameter int              WORD_W    = 16,
    parameter logic [WORD_W-1:0] INIT_WORD = 16'h5A3C,
    localparam int             AW        = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_one,
    input  logic              wr_all,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem_q [WORDS];

    // Storage update: reset fill, single-word write or broadcast write
    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (!rst_n) begin
                mem_q[i] <= INIT_WORD;
            end else if (wr_all || (wr_one && wr_addr == AW'(i))) begin
                mem_q[i] <= wr_data;
            end
        end
    end

    // Read port
    assign rd_data = mem_q[rd_addr];

    // The sequencer never asks for both write kinds at once
    assert_one_write_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_one && wr_all));

endmodule

// File: rtl/sws_fsm.sv
// Module: command sequencer for the serial protocol.
// Does: detects pin edges, shifts command and data bits, issues storage
//       writes, shifts read data out and works out the next data-out value.
// Assumes: CMD_BITS <= WORD_W and the address field holds the word address
//          in its low bits.
module sws_fsm
    import sws_pkg::*;
#(
    parameter int WORDS        = 128,
    parameter int WORD_W       = 16,
    parameter int ADDR_FIELD_W = 8,
    localparam int AW          = $clog2(WORDS),
    localparam int CMD_BITS    = ADDR_FIELD_W + 2,
    localparam int CNT_W       = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_we,
    input  logic              old_cs,
    input  logic              old_clk,
    input  logic              old_do,
    input  logic              new_cs,
    input  logic              new_clk,
    input  logic              new_di,
    input  logic [WORD_W-1:0] rd_word,
    output logic [AW-1:0]     rd_addr,
    output logic              wr_one,
    output logic              wr_all,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              do_new
);

    sws_state_e        state_q, state_d, st_start;
    logic [WORD_W-1:0] sr_q, sr_d, sr_shift;
    logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
    logic [AW-1:0]     addr_q, addr_d;
    logic              wen_q, wen_d;
    logic              cs_rise, clk_rise, hold_fall;
    logic [1:0]        opcode, ext_code;

    // Next-state logic for one window write
    always_comb begin
        cs_rise   = pin_we && !old_cs && new_cs;
        clk_rise  = pin_we && !old_clk && new_clk;
        hold_fall = pin_we && new_cs && old_clk && !new_clk;
        st_start  = cs_rise ? ST_IDLE : state_q;
        sr_shift  = {sr_q[WORD_W-2:0], new_di};
        cnt_inc   = cnt_q + 1'b1;
        opcode    = sr_shift[CMD_BITS-1 -: 2];
        ext_code  = sr_shift[CMD_BITS-3 -: 2];

        state_d = st_start;
        sr_d    = sr_q;
        cnt_d   = cnt_q;
        addr_d  = addr_q;
        wen_d   = wen_q;
        do_new  = 1'b1;
        wr_one  = 1'b0;
        wr_all  = 1'b0;
        wr_addr = addr_q;
        wr_data = sr_shift;
        rd_addr = sr_shift[AW-1:0];

        if (clk_rise) begin
            unique case (st_start)
                ST_IDLE: begin
                    if (new_di) begin
                        state_d = ST_CMD;
                        sr_d    = '0;
                        cnt_d   = '0;
                    end
                end
                ST_CMD: begin
                    sr_d  = sr_shift;
                    cnt_d = cnt_inc;
                    if (cnt_inc == CNT_W'(CMD_BITS)) begin
                        cnt_d  = '0;
                        addr_d = sr_shift[AW-1:0];
                        unique case (opcode)
                            OP_READ: begin
                                state_d = ST_DOUT;
                                sr_d    = rd_word;
                                cnt_d   = CNT_W'(WORD_W);
                                do_new  = 1'b0;
                            end
                            OP_WRITE: state_d = ST_WDATA;
                            OP_ERASE: begin
                                wr_one  = wen_q;
                                wr_addr = sr_shift[AW-1:0];
                                wr_data = '1;
                                state_d = ST_IDLE;
                            end
                            default: begin
                                unique case (ext_code)
                                    EXT_ALLOW:  begin wen_d = 1'b1; state_d = ST_IDLE; end
                                    EXT_FORBID: begin wen_d = 1'b0; state_d = ST_IDLE; end
                                    EXT_WALL:   state_d = ST_WALL;
                                    default: begin
                                        wr_all  = wen_q;
                                        wr_data = '1;
                                        state_d = ST_IDLE;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                ST_DOUT: begin
                    do_new = sr_q[WORD_W-1];
                    sr_d   = {sr_q[WORD_W-2:0], 1'b0};
                    cnt_d  = cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) state_d = ST_IDLE;
                end
                default: begin
                    sr_d  = sr_shift;
                    cnt_d = cnt_inc;
                    if (cnt_inc == CNT_W'(WORD_W)) begin
                        wr_one  = wen_q && (st_start == ST_WDATA);
                        wr_all  = wen_q && (st_start == ST_WALL);
                        state_d = ST_IDLE;
                    end
                end
            endcase
        end else if (hold_fall) begin
            do_new = old_do;
        end
    end

    // Sequencer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sr_q    <= '0;
            cnt_q   <= '0;
            addr_q  <= '0;
            wen_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sr_q    <= sr_d;
            cnt_q   <= cnt_d;
            addr_q  <= addr_d;
            wen_q   <= wen_d;
        end
    end

    // Chip select rising without a clock edge leaves the sequencer idle
    assert_cs_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !clk_rise) |=> state_q == ST_IDLE);

    // While shifting out, the remaining-bit count stays within one word
    assert_dout_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOUT) |-> (cnt_q >= CNT_W'(1) && cnt_q <= CNT_W'(WORD_W)));

    // A completed forbid command leaves the modify flag clear
    assert_forbid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_rise && st_start == ST_CMD && cnt_inc == CNT_W'(CMD_BITS)
         && opcode == OP_EXT && ext_code == EXT_FORBID) |=> !wen_q);

endmodule

// File: rtl/serial_word_store.sv
// Module: top of the bit-banged serial word store.
// Does: holds the pin register behind the two-key gate, feeds pin edges to
//       the sequencer and connects the sequencer to the word storage.
// Assumes: one bus write per cycle; bus_rdata is read combinationally.
module serial_word_store
    import sws_pkg::*;
#(
    parameter int              WORDS        = 128,
    parameter int              WORD_W       = 16,
    parameter int              ADDR_FIELD_W = 8,
    parameter logic [WORD_W-1:0] INIT_WORD  = 16'h5A3C,
    parameter int              REGION_W     = 3,
    parameter int              WIN_REGION   = 5,
    localparam int             AW           = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [REGION_W-1:0] bus_region,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata
);

    logic              win_open;
    logic              pin_we;
    logic [7:0]        pin_q;
    logic              do_new;
    logic [AW-1:0]     rd_addr, wr_addr;
    logic              wr_one, wr_all;
    logic [WORD_W-1:0] wr_data, rd_word;

    sws_unlock #(
        .REGION_W (REGION_W)
    ) u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_region (bus_region),
        .bus_wdata  (bus_wdata),
        .open_o     (win_open)
    );

    // A window write reaches the pins only while the gate is open
    assign pin_we = bus_wr && win_open && (bus_region == REGION_W'(WIN_REGION));

    sws_fsm #(
        .WORDS        (WORDS),
        .WORD_W       (WORD_W),
        .ADDR_FIELD_W (ADDR_FIELD_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_we  (pin_we),
        .old_cs  (pin_q[PIN_CS]),
        .old_clk (pin_q[PIN_CLK]),
        .old_do  (pin_q[PIN_DO]),
        .new_cs  (bus_wdata[PIN_CS]),
        .new_clk (bus_wdata[PIN_CLK]),
        .new_di  (bus_wdata[PIN_DI]),
        .rd_word (rd_word),
        .rd_addr (rd_addr),
        .wr_one  (wr_one),
        .wr_all  (wr_all),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .do_new  (do_new)
    );

    sws_array #(
        .WORDS     (WORDS),
        .WORD_W    (WORD_W),
        .INIT_WORD (INIT_WORD)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_one  (wr_one),
        .wr_all  (wr_all),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    // Pin register: written bits plus the data-out chosen by the sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 8'h01;
        end else if (pin_we) begin
            pin_q <= {bus_wdata[7:1], do_new};
        end
    end

    // Readback through the gate
    assign bus_rdata = win_open ? pin_q : 8'hFF;

    // A write while closed leaves the pin register untouched
    assert_closed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !win_open) |=> $stable(pin_q));

    // A falling clock with chip select high keeps data-out
    assert_fall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_we && bus_wdata[PIN_CS] && pin_q[PIN_CLK] && !bus_wdata[PIN_CLK])
        |=> pin_q[PIN_DO] == $past(pin_q[PIN_DO]));

endmodule

// File: tb/serial_word_store_bench.sv
module serial_word_store_bench;

    localparam int WIN  = 5;
    localparam int INIT = 16'h5A3C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_region = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural reference model state
    bit m_ka, m_kb;
    int m_pin, m_st, m_sr, m_n, m_addr;
    bit m_wen;
    int m_mem [128];

    always #2 clk = ~clk;

    serial_word_store u_serial_word_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_region (bus_region),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ka = 0; m_kb = 0; m_pin = 8'h01; m_st = 0; m_sr = 0; m_n = 0;
        m_addr = 0; m_wen = 0;
        foreach (m_mem[i]) m_mem[i] = INIT;
    endtask

    // Model of one window write (states: 0 idle 1 cmd 2 out 3 wdata 4 wall)
    task automatic model_pins(input int v);
        bit oc, ok, nc, nk, di;
        int dout, op, ex, a;
        oc = m_pin[7]; ok = m_pin[6]; nc = v[7]; nk = v[6]; di = v[1];
        dout = 1;
        if (!oc && nc) m_st = 0;
        if (!ok && nk) begin
            if (m_st == 1 || m_st == 3 || m_st == 4) begin
                m_sr = ((m_sr << 1) | di) & 16'hFFFF;
                m_n++;
            end
            case (m_st)
                0: if (di) begin m_st = 1; m_sr = 0; m_n = 0; end
                1: if (m_n == 10) begin
                    op = (m_sr >> 8) & 3; ex = (m_sr >> 6) & 3; a = m_sr & 127;
                    m_n = 0; m_addr = a;
                    if (op == 2) begin m_sr = m_mem[a]; m_n = 16; m_st = 2; dout = 0; end
                    else if (op == 1) m_st = 3;
                    else if (op == 3) begin if (m_wen) m_mem[a] = 16'hFFFF; m_st = 0; end
                    else if (ex == 3) begin m_wen = 1; m_st = 0; end
                    else if (ex == 0) begin m_wen = 0; m_st = 0; end
                    else if (ex == 1) m_st = 4;
                    else begin
                        if (m_wen) foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
                        m_st = 0;
                    end
                end
                2: begin
                    dout = (m_sr >> 15) & 1;
                    m_sr = (m_sr << 1) & 16'hFFFF;
                    m_n--;
                    if (m_n == 0) m_st = 0;
                end
                3: if (m_n == 16) begin if (m_wen) m_mem[m_addr] = m_sr; m_st = 0; end
                4: if (m_n == 16) begin
                    if (m_wen) foreach (m_mem[i]) m_mem[i] = m_sr;
                    m_st = 0;
                end
                default: ;
            endcase
        end else if (nc && ok && !nk) begin
            dout = m_pin & 1;
        end
        m_pin = (v & 8'hFE) | dout;
    endtask

    task automatic model_bus(input int rg, input int d);
        if (rg == WIN && m_ka && m_kb) model_pins(d);
        if (rg == 0) begin
            if (d == 8'h0A) m_ka = 1; else begin m_ka = 0; m_kb = 0; end
        end
        if (rg == 2) m_kb = (d == 8'h40);
    endtask

    // One bus cycle, then compare the readback with the model (R3)
    task automatic step(input bit wr, input int rg, input int d);
        bus_wr = wr; bus_region = rg[2:0]; bus_wdata = d[7:0];
        if (wr) model_bus(rg, d);
        @(negedge clk);
        check("R3 cycle", bus_rdata, (m_ka && m_kb) ? m_pin : 8'hFF);
        bus_wr = 1'b0;
    endtask

    task automatic pin(input int v);
        step(1, WIN, v);
    endtask

    task automatic sbit(input bit di, output bit dob);
        pin({24'd0, 1'b1, 1'b0, 4'd0, di, 1'b0});
        pin({24'd0, 1'b1, 1'b1, 4'd0, di, 1'b0});
        dob = bus_rdata[0];
    endtask

    task automatic send_cmd(input int op, input int field, output bit last_do);
        bit b;
        pin(8'h00);
        pin(8'h80);
        sbit(1'b1, b);
        for (int i = 1; i >= 0; i--) sbit(op[i], b);
        for (int i = 7; i >= 0; i--) sbit(field[i], b);
        last_do = b;
    endtask

    task automatic read_word(input int a, output int w, output bit dummy);
        bit b;
        send_cmd(2, a, dummy);
        w = 0;
        for (int i = 0; i < 16; i++) begin
            sbit(1'b0, b);
            w = (w << 1) | b;
        end
        pin(8'h00);
    endtask

    task automatic send_data(input int d);
        bit b;
        for (int i = 15; i >= 0; i--) sbit(d[i], b);
        pin(8'h00);
    endtask

    task automatic ext_cmd(input int code);
        bit b;
        send_cmd(0, code << 6, b);
        pin(8'h00);
    endtask

    // Watchdog
    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w;
        bit dm, b, held;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 / R2: closed after reset
        step(0, 0, 0);
        check("R2 closed read", bus_rdata, 8'hFF);
        // R1: key A alone does not open
        step(1, 0, 8'h0A);
        check("R1 key A only", bus_rdata, 8'hFF);
        step(1, 2, 8'h40);
        check("R12 reset pin value", bus_rdata, 8'h01);
        // R3: readback of written bits with DO high
        pin(8'h82);
        check("R3 readback", bus_rdata, 8'h83);
        pin(8'h00);
        // R10 / R12: read initial content and dummy bit
        read_word(5, w, dm);
        check("R10 dummy bit", dm, 0);
        check("R12 init word", w, INIT);
        // R6: write while forbidden changes nothing
        send_cmd(1, 5, b); send_data(16'h1234);
        read_word(5, w, dm);
        check("R6 forbidden write", w, INIT);
        // R7 / R5: allow, then write with address bit 7 set (ignored)
        ext_cmd(3);
        send_cmd(1, 8'h85, b); send_data(16'h1234);
        read_word(5, w, dm);
        check("R7 word write", w, 16'h1234);
        read_word(6, w, dm);
        check("R5 neighbour untouched", w, INIT);
        // R9: erase one word
        send_cmd(3, 5, b); pin(8'h00);
        read_word(5, w, dm);
        check("R9 erase", w, 16'hFFFF);
        // R8: write-all
        send_cmd(0, 1 << 6, b); send_data(16'h0F0F);
        read_word(0, w, dm);
        check("R8 write-all low", w, 16'h0F0F);
        read_word(127, w, dm);
        check("R8 write-all high", w, 16'h0F0F);
        // R4: abort a half-sent command, then a clean read
        pin(8'h00); pin(8'h80);
        sbit(1'b1, b); sbit(1'b0, b); sbit(1'b1, b); sbit(1'b1, b);
        read_word(9, w, dm);
        check("R4 restart", w, 16'h0F0F);
        // R11: hold on falling edge mid-read, release on a non-edge write
        send_cmd(2, 3, dm);
        sbit(1'b0, b);
        check("R11 first data bit", b, 0);
        sbit(1'b0, b);
        check("R11 second data bit", b, 0);
        sbit(1'b0, b);
        check("R11 third data bit", b, 0);
        sbit(1'b0, b);
        check("R11 fourth data bit", b, 0);
        sbit(1'b0, b);
        check("R11 fifth data bit", b, 1);
        pin(8'h80);
        held = bus_rdata[0];
        check("R11 falling hold", held, 1);
        pin(8'h80);
        check("R11 released high", bus_rdata[0], 1);
        for (int i = 0; i < 11; i++) sbit(1'b0, b);
        pin(8'h00);
        // R9: erase-all
        ext_cmd(2);
        read_word(9, w, dm);
        check("R9 erase-all", w, 16'hFFFF);
        // R6: forbid then write
        ext_cmd(0);
        send_cmd(1, 3, b); send_data(16'h0000);
        read_word(3, w, dm);
        check("R6 forbid blocks", w, 16'hFFFF);
        // R1 / R2: wrong key B closes; window write ignored; B alone reopens
        step(1, 2, 8'h00);
        check("R1 key B cleared", bus_rdata, 8'hFF);
        pin(8'hC2);
        step(1, 2, 8'h40);
        check("R2 ignored while closed", bus_rdata, 8'h01);
        // R1: wrong key A clears both
        step(1, 0, 8'h11);
        step(1, 0, 8'h0A);
        check("R1 both cleared", bus_rdata, 8'hFF);
        step(1, 2, 8'h40);
        check("R1 reopened", bus_rdata, 8'h01);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule